// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block divides a reference clock down to a one-cycle enable pulse at sixteen times the serial bit rate. The serial transmitter and receiver use this pulse as their sampling and shifting enable. The divisor has a 16-bit integer part and a 6-bit fractional part, so it is set in steps of 1/64.

The fractional part is realised by dithering. A 6-bit accumulator adds the fractional value once per pulse. Each time it carries out, the next pulse interval lasts one reference cycle longer than the integer part. Over 64 pulses the intervals average to exactly the programmed divisor. This lets common bit rates be reached from reference clocks that are not an exact multiple of them.

The divisor inputs are sampled only when the configuration write strobe is high, so both halves change together. The same strobe restarts the period counter and clears the accumulator. An integer part of zero is illegal and stops the pulses. The fastest setting is an integer part of 1 with no fraction, which gives a pulse every reference cycle and so a bit rate of the reference clock divided by 16.

Top module: `baud_x16_gen`

## Requirements
- R1: After a synchronous reset, `tick_x16_o` is low and stays low until the first configuration write, even when the divisor inputs hold nonzero values.
- R2: With integer part N ≥ 1 and fractional part 0, the first pulse appears N cycles after the write edge and later pulses follow every N cycles. N = 1 drives the output high on every cycle.
- R3: For N ≥ 2, every pulse is exactly one reference cycle wide.
- R4: With integer part N and fractional part F, the k-th pulse after a write is seen at write edge + k·N + floor((k−1)·F/64) edges. The distance from pulse 1 to pulse 65 is therefore exactly 64·N + F cycles.
- R5: Changes on `div_int_i` or `div_frac_i` have no effect on pulse timing while `cfg_wr_i` is low.
- R6: A configuration write restarts the sequence. The output is low in the cycle after the write edge, and the next pulse timing follows R2/R4 counted from that edge, whatever phase the previous setting was in.
- R7: An integer part of 0 holds `tick_x16_o` low for any fractional value.
- R8: The largest integer part, 65535, places the first pulse exactly 65535 cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_int_i | input | 16 | Integer part of the divisor |
| div_frac_i | input | 6 | Fractional part of the divisor, in 1/64 units |
| cfg_wr_i | input | 1 | Write strobe: loads both divisor halves and restarts |
| tick_x16_o | output | 1 | One-cycle enable pulse at 16 × bit rate |

## Verification
Every fractional value from 0 to 63 is swept for integer parts 1 to 4. Each configuration is compared cycle by cycle against the closed-form pulse times. This separates an accumulator that carries at the wrong pulse, an off-by-one in the period, and a stretch applied to the wrong interval. The 64-pulse span isolates the average divisor from local dithering order. Each new configuration is written while the previous one is still running, which tests the restart. A disturbed-input run, a zero integer part and the largest integer part cover the ignore, stop and counter-width corners.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int DEF_INT_W  = 16;
  localparam int DEF_FRAC_W = 6;

  typedef enum logic {
    GEN_STOPPED = 1'b0,
    GEN_RUNNING = 1'b1
  } gen_state_e;
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      int_o  <= '0;
      frac_o <= '0;
    end else if (wr_i) begin
      int_o  <= int_i;
      frac_o <= frac_i;
    end
  end

  // R5: divisor only moves on a write
  assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> ($stable(int_o) && $stable(frac_o)));
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              stretch_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      acc_q     <= '0;
      stretch_o <= 1'b0;
    end else if (step_i) begin
      acc_q     <= sum[FRAC_W-1:0];
      stretch_o <= sum[FRAC_W];
    end
  end

  // R4: a zero fraction never stretches a period
  assert_no_stretch_zero_frac_R4: assert property (@(posedge clk) disable iff (rst)
    (frac_i == '0 && !restart_i) |=> (frac_i != '0 || !stretch_o));
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt
  import baud_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [INT_W-1:0] div_int_i,
  input  logic             stretch_i,
  output logic             last_o,
  output logic             tick_o
);
  localparam int PER_W = INT_W + 1;

  gen_state_e       state;
  logic [INT_W-1:0] cnt_q;
  logic [PER_W-1:0] period;

  always_comb begin
    state  = (div_int_i == '0) ? GEN_STOPPED : GEN_RUNNING;
    period = {1'b0, div_int_i} + PER_W'(stretch_i);
    last_o = (state == GEN_RUNNING) && !restart_i &&
             ({1'b0, cnt_q} == period - PER_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i || state == GEN_STOPPED) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (last_o) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + INT_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R7: zero divisor keeps the output low
  assert_zero_div_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (div_int_i == '0) |-> !tick_o);
  // R3: single-cycle pulse once the period is two or more
  assert_pulse_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_o && period >= PER_W'(2)) |=> !tick_o);
  // R2: counter never passes the current period
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    (state == GEN_RUNNING) |-> ({1'b0, cnt_q} < period));
  // R6: a write leaves the output low on the next cycle
  assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !tick_o);
endmodule

// File: rtl/baud_x16_gen.sv
module baud_x16_gen
  import baud_pkg::*;
#(
  parameter int INT_W  = DEF_INT_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic              cfg_wr_i,
  output logic              tick_x16_o
);
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic              stretch;
  logic              last;

  baud_div_latch #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_latch (
    .clk(clk), .rst(rst), .wr_i(cfg_wr_i),
    .int_i(div_int_i), .frac_i(div_frac_i),
    .int_o(act_int), .frac_o(act_frac)
  );

  baud_frac_acc #(.FRAC_W(FRAC_W)) i_acc (
    .clk(clk), .rst(rst), .restart_i(cfg_wr_i),
    .step_i(last), .frac_i(act_frac), .stretch_o(stretch)
  );

  baud_period_cnt #(.INT_W(INT_W)) i_cnt (
    .clk(clk), .rst(rst), .restart_i(cfg_wr_i),
    .div_int_i(act_int), .stretch_i(stretch),
    .last_o(last), .tick_o(tick_x16_o)
  );

  // R1: output low out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !tick_x16_o);
endmodule

// File: tb/test_baud_x16_gen.sv
module test_baud_x16_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic        cfg_wr = 1'b0;
  logic        tick;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  baud_x16_gen i_baud_x16_gen (
    .clk(clk), .rst(rst), .div_int_i(div_int), .div_frac_i(div_frac),
    .cfg_wr_i(cfg_wr), .tick_x16_o(tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // write N/F; returns after the negedge that follows the write edge
  task automatic write_cfg(input int n, input int f);
    @(negedge clk);
    div_int = 16'(n); div_frac = 6'(f); cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    check(tick == 1'b0, "R6", "output after write", tick, 0);
  endtask

  // compare against t_k = k*N + floor((k-1)*F/64) for npulse pulses
  task automatic sweep(input int n, input int f, input int npulse, input bit disturb);
    int j = 1;
    int tnext = n;
    int t1 = -1;
    int t65 = -1;
    int first_bad = -1;
    int bad_act = 0;
    bit prev = 1'b0;
    bit wide = 1'b0;
    int span = npulse * n + ((npulse - 1) * f) / 64;
    for (int k = 1; k <= span; k++) begin
      bit exp;
      @(negedge clk);
      if (disturb && k == 5) begin
        div_int = 16'(n + 4); div_frac = 6'(63 - f);
      end
      exp = (k == tnext);
      if (tick !== exp && first_bad < 0) begin
        first_bad = k; bad_act = tick;
      end
      if (tick && prev && n >= 2) wide = 1'b1;
      prev = tick;
      if (tick && j == 1 && t1 < 0) t1 = k;
      if (tick && k == tnext && j == 65) t65 = k;
      if (exp) begin
        j++;
        tnext = j * n + ((j - 1) * f) / 64;
      end
    end
    if (disturb)
      check(first_bad < 0, "R5", $sformatf("N=%0d F=%0d inputs moved, first mismatch cycle %0d tick", n, f, first_bad), bad_act, bad_act ^ 1);
    else if (f == 0)
      check(first_bad < 0, "R2", $sformatf("N=%0d first mismatch cycle %0d tick", n, first_bad), bad_act, bad_act ^ 1);
    else
      check(first_bad < 0, "R4", $sformatf("N=%0d F=%0d first mismatch cycle %0d tick", n, f, first_bad), bad_act, bad_act ^ 1);
    if (n >= 2)
      check(!wide, "R3", $sformatf("N=%0d F=%0d pulse wider than one cycle", n, f), wide, 0);
    if (npulse >= 65 && !disturb)
      check(t65 - t1 == 64 * n + f, "R4", $sformatf("N=%0d F=%0d span of 64 pulses", n, f), t65 - t1, 64 * n + f);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int highs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    div_int = 16'd2; div_frac = 6'd9;
    // R1: no write yet, inputs nonzero
    highs = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (tick) highs++;
    end
    check(highs == 0, "R1", "pulses before first write", highs, 0);

    // exhaustive sweep; each write lands on a running configuration (R6)
    for (int n = 1; n <= 4; n++)
      for (int f = 0; f < 64; f++) begin
        write_cfg(n, f);
        sweep(n, f, 66, 1'b0);
      end

    // R5: inputs change mid-run without a write
    write_cfg(3, 20);
    sweep(3, 20, 40, 1'b1);

    // R6: write in the middle of a period
    write_cfg(6, 0);
    repeat (4) @(negedge clk);
    write_cfg(5, 33);
    sweep(5, 33, 66, 1'b0);

    // R7: zero integer part
    write_cfg(0, 37);
    highs = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (tick) highs++;
    end
    check(highs == 0, "R7", "pulses with zero integer part", highs, 0);

    // R1: reset in the middle of a run
    write_cfg(2, 0);
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    highs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tick) highs++;
    end
    check(highs == 0, "R1", "pulses after reset", highs, 0);

    // R8: largest integer part
    write_cfg(65535, 0);
    begin
      int first = -1;
      for (int k = 1; k <= 65536; k++) begin
        @(negedge clk);
        if (tick && first < 0) first = k;
      end
      check(first == 65535, "R8", "first pulse cycle at max divisor", first, 65535);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule